// File: doc/BRIEF.md
# Frame Synchronizer with Alignment Tracking

This block follows a decoded serial bit stream, one bit per cycle in which a bit-valid qualifier is high, and looks for a fixed alignment word that repeats once per frame. Until it has locked, it reports out-of-frame. Once it has locked, it produces a start-of-frame pulse and a data-enable level that line up with the incoming bits, so that downstream logic can pick the payload out of the stream.

When the alignment word is lost, the block goes back to out-of-frame and hunts again. While it hunts, its strobes keep the timing of the last good alignment. If the next lock lands on a different bit position, the strobes jump to the new position and a sticky change-of-alignment flag is raised, which stays set until it is cleared. Before the first lock after reset, the strobes come from a free-running counter that has no relation to the data.

The strobes are combinational from a registered bit-position counter, so they qualify the bit that is on the input in the same cycle. Frame length, word length, word value, lock count and loss count are parameters. The defaults are a 1536-bit frame, a 10-bit word, 3 frames to lock and 4 frames to loss.

Top module: `frame_sync_align`

## Requirements
- R1: During and after reset, `oof` is 1 and `cofa` is 0, and both stay that way until the first lock.
- R2: Before the first lock, `sof` pulses on valid bits 0, FRAME_LEN, 2*FRAME_LEN and so on, counting valid bits from reset. `den` is high on every valid bit except the first FAW_LEN bits of each of those periods.
- R3: `sof` is high for exactly one valid bit per frame, on frame bit position 0. `den` is low on positions 0 to FAW_LEN-1 (the alignment word) and high on all later positions.
- R4: The alignment word is sent MSB first (default 1111010000) in frame positions 0 to FAW_LEN-1. Lock requires the word to end on the same bit offset in LOCK_CNT consecutive frames. `oof` falls on the bit after the last word bit of the locking frame, and from that bit on the strobes follow the locked frame.
- R5: A frame with no correct word at the candidate offset during the hunt drops the candidate. Lock then needs LOCK_CNT fresh consecutive hits.
- R6: While locked, `oof` rises on the bit after the word of the LOSS_CNT-th consecutive frame whose word is in error. A correct word resets this count, so fewer than LOSS_CNT errored frames in a row leave `oof` low.
- R7: During a hunt that follows a loss, `sof` and `den` keep the phase of the last lock.
- R8: `cofa` rises on the bit after a lock whose position differs from the previous lock. It stays 0 after the first lock after reset, and after a re-lock at the same position.
- R9: `cofa` stays 1 until a cycle with `cofa_clr` high and no differing lock. It is 0 from the next cycle on.
- R10: In a cycle with `bit_valid` low, `sof` and `den` are 0. No counter, status or the word history advances in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | Qualifies `bit_data` for this cycle |
| bit_data | input | 1 | Decoded serial data bit |
| cofa_clr | input | 1 | Clears the sticky change-of-alignment flag |
| oof | output | 1 | Out-of-frame status |
| sof | output | 1 | Start-of-frame pulse on frame bit 0 |
| den | output | 1 | Data enable, low across the alignment word |
| cofa | output | 1 | Sticky change-of-alignment flag |

## Verification
A wrong bit-position counter shows at once as a `sof` or `den` edge on the wrong bit, and no later than one frame after the fault. A wrong hit count or miss count moves the fall or rise of `oof` by whole frames, so each lock and each loss is checked against the exact bit index at which it should happen. A candidate that is started or dropped wrongly during the hunt shows the same way, as a lock one or more frames early or late. A bad comparison of old and new phase shows on `cofa` on the bit after a re-lock. The run covers two re-locks: one at a new offset and one at the old offset.

// File: rtl/fsync_pkg.sv
// Shared types for the frame synchronizer.
package fsync_pkg;
    // Top-level synchronizer states.
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } fs_state_e;
endpackage

// File: rtl/fs_bit_timer.sv
// Frame bit-position counter. It advances once per valid bit and wraps at
// FRAME_LEN. A load request puts it on the bit that follows the alignment
// word. Assumes 2 <= FAW_LEN < FRAME_LEN.
module fs_bit_timer #(
    parameter int FRAME_LEN = 1536,
    parameter int FAW_LEN   = 10,
    localparam int POS_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    output logic [POS_W-1:0] pos,
    output logic             word_end
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] LOAD_POS = POS_W'(FAW_LEN);
    localparam logic [POS_W-1:0] END_POS  = POS_W'(FAW_LEN - 1);

    // Advance or reload the position on each valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (step) begin
            if (load)
                pos <= LOAD_POS;
            else if (pos == LAST_POS)
                pos <= '0;
            else
                pos <= pos + 1'b1;
        end
    end

    // The current bit is the last bit of the alignment word.
    assign word_end = (pos == END_POS);
endmodule

// File: rtl/fs_word_det.sv
// Alignment word detector. It compares the last FAW_LEN bits, counting the
// current one, with the word. Bits arrive MSB first.
module fs_word_det #(
    parameter int                 FAW_LEN = 10,
    parameter logic [FAW_LEN-1:0] FAW     = 10'b1111010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic din,
    output logic hit
);
    logic [FAW_LEN-2:0] hist;
    logic [FAW_LEN-1:0] window;

    // Window of earlier bits with the current bit appended.
    assign window = {hist, din};
    assign hit    = (window == FAW);

    // Shift in each valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (step)
            hist <= window[FAW_LEN-2:0];
    end
endmodule

// File: rtl/fs_sync_ctrl.sv
// Hunt and lock controller. During a hunt, one candidate offset is tracked
// with its own position counter and confirmed over LOCK_CNT frames. Once
// locked, errored words are counted and loss is declared after LOSS_CNT in a
// row. The change-of-alignment flag is set when a re-lock does not match the
// phase of the main counter. Assumes LOCK_CNT >= 2 and LOSS_CNT >= 1.
module fs_sync_ctrl
    import fsync_pkg::*;
#(
    parameter int FRAME_LEN = 1536,
    parameter int FAW_LEN   = 10,
    parameter int LOCK_CNT  = 3,
    parameter int LOSS_CNT  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic hit,
    input  logic main_end,
    input  logic cofa_clr,
    output logic oof,
    output logic realign,
    output logic cofa
);
    localparam int POS_W  = $clog2(FRAME_LEN);
    localparam int HIT_W  = $clog2(LOCK_CNT + 1);
    localparam int MISS_W = $clog2(LOSS_CNT + 1);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0]  LOAD_POS  = POS_W'(FAW_LEN);
    localparam logic [POS_W-1:0]  END_POS   = POS_W'(FAW_LEN - 1);
    localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_CNT - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_CNT - 1);

    fs_state_e          state;
    logic [HIT_W-1:0]   hits;
    logic [MISS_W-1:0]  misses;
    logic [POS_W-1:0]   cand_pos;
    logic               cand_act;
    logic               had_lock;
    logic               cand_end;
    logic               lock_now;
    logic               loss_now;

    // Decode of the candidate word position and of the lock and loss events.
    always_comb begin
        cand_end = cand_act && (cand_pos == END_POS);
        lock_now = step && (state == ST_HUNT) && cand_end && hit && (hits == HIT_LAST);
        loss_now = step && (state == ST_LOCK) && main_end && !hit && (misses == MISS_LAST);
    end

    assign oof     = (state == ST_HUNT);
    assign realign = lock_now;

    // Run the hunt and lock sequence once per valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            hits     <= '0;
            misses   <= '0;
            cand_pos <= '0;
            cand_act <= 1'b0;
            had_lock <= 1'b0;
        end else if (step) begin
            case (state)
                ST_HUNT: begin
                    if (!cand_act) begin
                        if (hit) begin
                            cand_act <= 1'b1;
                            hits     <= HIT_W'(1);
                            cand_pos <= LOAD_POS;
                        end
                    end else begin
                        cand_pos <= (cand_pos == LAST_POS) ? '0 : cand_pos + 1'b1;
                        if (cand_end) begin
                            if (lock_now) begin
                                state    <= ST_LOCK;
                                cand_act <= 1'b0;
                                misses   <= '0;
                                had_lock <= 1'b1;
                            end else if (hit) begin
                                hits <= hits + 1'b1;
                            end else begin
                                cand_act <= 1'b0;
                            end
                        end
                    end
                end
                ST_LOCK: begin
                    if (main_end) begin
                        if (hit)
                            misses <= '0;
                        else if (loss_now) begin
                            state  <= ST_HUNT;
                            misses <= '0;
                        end else
                            misses <= misses + 1'b1;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // Sticky change-of-alignment flag. A set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cofa <= 1'b0;
        else if (lock_now && had_lock && !main_end)
            cofa <= 1'b1;
        else if (cofa_clr)
            cofa <= 1'b0;
    end
endmodule

// File: rtl/frame_sync_align.sv
// Frame synchronizer top. It ties the main bit-position counter, the word
// detector and the hunt and lock controller together, and decodes the
// strobes from the counter for the bit on the input in this cycle.
module frame_sync_align #(
    parameter int                 FRAME_LEN = 1536,
    parameter int                 FAW_LEN   = 10,
    parameter logic [FAW_LEN-1:0] FAW       = 10'b1111010000,
    parameter int                 LOCK_CNT  = 3,
    parameter int                 LOSS_CNT  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_data,
    input  logic cofa_clr,
    output logic oof,
    output logic sof,
    output logic den,
    output logic cofa
);
    localparam int POS_W = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] FIRST_DATA = POS_W'(FAW_LEN);

    logic [POS_W-1:0] main_pos;
    logic             main_end;
    logic             hit;
    logic             realign;

    fs_bit_timer #(.FRAME_LEN(FRAME_LEN), .FAW_LEN(FAW_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .step(bit_valid), .load(realign),
        .pos(main_pos), .word_end(main_end)
    );

    fs_word_det #(.FAW_LEN(FAW_LEN), .FAW(FAW)) u_det (
        .clk(clk), .rst_n(rst_n), .step(bit_valid), .din(bit_data), .hit(hit)
    );

    fs_sync_ctrl #(
        .FRAME_LEN(FRAME_LEN), .FAW_LEN(FAW_LEN),
        .LOCK_CNT(LOCK_CNT), .LOSS_CNT(LOSS_CNT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .step(bit_valid), .hit(hit),
        .main_end(main_end), .cofa_clr(cofa_clr),
        .oof(oof), .realign(realign), .cofa(cofa)
    );

    // Strobes for the current valid bit.
    always_comb begin
        sof = bit_valid && (main_pos == '0);
        den = bit_valid && (main_pos >= FIRST_DATA);
    end
endmodule

// File: rtl/fsync_checker.sv
// Port-level properties of the frame synchronizer, bound to the top.
module fsync_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_valid,
    input logic cofa_clr,
    input logic oof,
    input logic sof,
    input logic den,
    input logic cofa
);
    AST_SOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> bit_valid); // R10
    AST_SOF_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> !den); // R3
    AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oof) |-> $past(bit_valid)); // R4
    AST_COFA_AT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cofa) |-> $fell(oof)); // R8
    AST_COFA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cofa && !cofa_clr |=> cofa); // R9
    AST_COFA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cofa_clr && !bit_valid |=> !cofa); // R9
    AST_OOF_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(oof)); // R10
endmodule

bind frame_sync_align fsync_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .cofa_clr(cofa_clr),
    .oof(oof), .sof(sof), .den(den), .cofa(cofa)
);

// File: tb/sim_frame_sync_align.sv
module sim_frame_sync_align;
    localparam int F = 80;
    localparam int W = 10;
    localparam logic [W-1:0] WORD = 10'b1111010000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_data = 1'b0;
    logic cofa_clr = 1'b0;
    logic oof, sof, den, cofa;

    always #2.5 clk = ~clk;

    frame_sync_align #(.FRAME_LEN(F), .FAW_LEN(W), .FAW(WORD),
                       .LOCK_CNT(3), .LOSS_CNT(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
        .cofa_clr(cofa_clr), .oof(oof), .sof(sof), .den(den), .cofa(cofa)
    );

    typedef struct {
        bit    oof;
        bit    sof;
        bit    den;
        bit    cofa;
        string tag;
        int    idx;
    } exp_t;

    exp_t  q[$];
    int    total = 0;
    int    bad = 0;
    int    bi = 0;
    int    base = 0;
    bit    e_oof = 1'b1;
    bit    e_cofa = 1'b0;
    string tag = "R2";
    bit    done = 1'b0;
    bit    mon_on = 1'b0;

    // Push one bit, with an idle cycle inserted now and then.
    task automatic put_bit(input bit d);
        exp_t e;
        int m;
        if (bi % 11 == 7) begin
            @(negedge clk);
            bit_valid = 1'b0;
            bit_data  = 1'b0;
        end
        @(negedge clk);
        bit_valid = 1'b1;
        bit_data  = d;
        m = (bi - base) % F;
        if (m < 0) m += F;
        e.oof  = e_oof;
        e.sof  = (m == 0);
        e.den  = (m >= W);
        e.cofa = e_cofa;
        e.tag  = tag;
        e.idx  = bi;
        q.push_back(e);
        bi++;
    endtask

    task automatic send_zeros(input int n);
        for (int k = 0; k < n; k++) put_bit(1'b0);
    endtask

    // ev: 0 none, 1 lock, 2 lock at new offset, 3 loss (all at the word end).
    task automatic send_frame(input bit good, input int ev);
        int fs;
        bit d;
        fs = bi;
        for (int j = 0; j < F; j++) begin
            if (j < W) d = (j == 0 && !good) ? 1'b0 : WORD[W-1-j];
            else       d = 1'b0;
            put_bit(d);
            if (j == W - 1) begin
                if (ev == 1 || ev == 2) begin
                    e_oof = 1'b0;
                    base  = fs;
                    if (ev == 2) e_cofa = 1'b1;
                end else if (ev == 3) begin
                    e_oof = 1'b1;
                end
            end
        end
    endtask

    task automatic clear_cofa();
        @(negedge clk);
        bit_valid = 1'b0;
        cofa_clr  = 1'b1;
        @(negedge clk);
        cofa_clr  = 1'b0;
        e_cofa    = 1'b0;
    endtask

    // Monitor: compare each valid bit with the scoreboard, and idle cycles with zero strobes.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on) begin
                if (bit_valid) begin
                    if (q.size() == 0) begin
                        total++; bad++;
                        $display("FAIL scoreboard empty: unexpected bit, actual valid=1 expected none");
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        total++;
                        if ({oof, sof, den, cofa} !== {e.oof, e.sof, e.den, e.cofa}) begin
                            bad++;
                            $display("FAIL %s bit %0d oof/sof/den/cofa actual=%b%b%b%b expected=%b%b%b%b",
                                     e.tag, e.idx, oof, sof, den, cofa, e.oof, e.sof, e.den, e.cofa);
                        end
                    end
                end else begin
                    total++;
                    if (sof !== 1'b0 || den !== 1'b0) begin
                        bad++;
                        $display("FAIL R10 idle cycle sof/den actual=%b%b expected=00", sof, den);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (4) @(negedge clk);
        #1;
        total++;
        if ({oof, cofa, sof, den} !== 4'b1000) begin
            bad++;
            $display("FAIL R1 in reset oof/cofa/sof/den actual=%b%b%b%b expected=1000", oof, cofa, sof, den);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        total++;
        if ({oof, cofa} !== 2'b10) begin
            bad++;
            $display("FAIL R1 after reset oof/cofa actual=%b%b expected=10", oof, cofa);
        end
        mon_on = 1'b1;

        // R2: free-running strobes, then the first lock (R4) with no cofa (R8).
        tag = "R2";
        send_zeros(23);
        send_frame(1'b1, 0);
        send_frame(1'b1, 0);
        tag = "R4";
        send_frame(1'b1, 1);
        tag = "R3";
        send_frame(1'b1, 0);
        send_frame(1'b1, 0);

        // R6: three errored frames are tolerated, the fourth in a row loses lock.
        tag = "R6";
        send_frame(1'b0, 0);
        send_frame(1'b0, 0);
        send_frame(1'b0, 0);
        send_frame(1'b1, 0);
        send_frame(1'b0, 0);
        send_frame(1'b0, 0);
        send_frame(1'b0, 0);
        send_frame(1'b0, 3);

        // R7: the hunt keeps the old phase; R8: re-lock at a new offset sets cofa.
        tag = "R7";
        send_zeros(37);
        send_frame(1'b1, 0);
        send_frame(1'b1, 0);
        tag = "R8";
        send_frame(1'b1, 2);

        // R9: sticky until cleared.
        tag = "R9";
        send_frame(1'b1, 0);
        send_frame(1'b1, 0);
        clear_cofa();
        send_frame(1'b1, 0);

        // R5: a broken candidate restarts the count; the re-lock at the same offset leaves cofa 0 (R8).
        tag = "R6";
        send_frame(1'b0, 0);
        send_frame(1'b0, 0);
        send_frame(1'b0, 0);
        send_frame(1'b0, 3);
        tag = "R5";
        send_frame(1'b1, 0);
        send_frame(1'b0, 0);
        send_frame(1'b1, 0);
        send_frame(1'b1, 0);
        send_frame(1'b1, 1);
        tag = "R8";
        send_frame(1'b1, 0);

        @(negedge clk);
        bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R3 scoreboard left over actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule